// File: doc/BRIEF.md
# Programmable Divide-by-N Counter

This block divides an input clock by a programmable ratio N and emits one output pulse per N input clocks. The count is built from a first counting section, three cascaded decimal (BCD) decade sections and a last counting section. A three-bit mode word chooses the modulus of the first section (2, 4, 5, 8 or 10). The same word decides how the four low jam bits are split between the first and last sections. The remaining twelve jam bits give three decimal digits for the decades. When the count reaches its end, the counter reloads the whole jam value in the same cycle that the output goes high, so the ratio repeats without gaps.

A preset mode parks the counter. Leaving it takes one arming cycle, so the first output pulse comes one count later than in steady running. A preset request that arrives two or fewer counts before a pulse is due does not stop that pulse. A latch enable input lets the output stay high after a pulse until software-independent logic lowers the enable.

The controller is a three-state machine:
- PRESET: parked.
- ARM: one cycle after leaving preset.
- COUNT: counting down.

Its transitions are:
- PRESET→ARM when the preset code is removed. This edge also loads the jam value.
- ARM→COUNT on the next edge, or ARM→PRESET if preset returns.
- COUNT→COUNT on every step, and at the terminal count, where the jam value is reloaded.
- COUNT→PRESET when preset is requested with more than two counts left, or at the terminal count if preset is still requested at that point.

Top module: `divn_counter`

## Requirements
- R1: Mode word {sel_a, sel_b, sel_c}, where jam[0] is the least significant of the four low bits:

  | Mode | First section | First section uses | Last section | Last section uses |
  |---|---|---|---|---|
  | 111 | ÷2 | jam[0] | ÷8 | jam[3:1] |
  | 011 | ÷4 | jam[1:0] | ÷4 | jam[3:2] |
  | 101 | ÷5 | jam[2:0] | ÷2 | jam[3] |
  | 001 | ÷8 | jam[2:0] | ÷2 | jam[3] |
  | x10 | ÷10 | jam[3:0] | ÷1 | none |

  In mode x10, sel_a has no effect.
- R2: N = m × (1000·last + 100·jam[15:12] + 10·jam[11:8] + jam[7:4]) + first, where m is the first-section modulus. A decade digit above 9 counts as 9. A first-section jam above m−1 counts as m−1. The largest ratio is 15999 in the ÷2, ÷4 and ÷8 modes and 9999 in the ÷5 and ÷10 modes.
- R3: In steady counting, q rises once every N clocks. The jam value is reloaded at the same edge where q rises. With latch_en low, q stays high for exactly one clock.
- R4: sel_b = 0 and sel_c = 0 select preset, whatever sel_a is. While the block is parked, q produces no new pulse.
- R5: After preset is released, the first edge arms the counter and counting starts on the second edge. The first rising edge of q therefore comes N+1 edges after the first non-preset edge, at edge N+2 when that edge is counted as edge 1.
- R6: A preset request seen when two or fewer counts remain still lets the due pulse appear on time, and the counter then parks. A request seen with more counts remaining parks the counter at once.
- R7: While latch_en is high, q stays high once a pulse has occurred. q falls on the first edge after latch_en goes low, unless that edge is itself a terminal count.
- R8: A jam value that gives N = 0 or N = 1 makes q high on every counting cycle.
- R9: rst_n low (asynchronous) forces the PRESET state and q = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset into preset |
| sel_a | input | 1 | Mode select bit a |
| sel_b | input | 1 | Mode select bit b |
| sel_c | input | 1 | Mode select bit c |
| latch_en | input | 1 | Hold q high after a pulse while high |
| jam | input | 16 | Division value: low section bits, then three BCD digits |
| q | output | 1 | Divided output pulse |

## Verification
A wrong section value or a broken borrow between sections shows up as a pulse period different from N. It is seen at the first pulse after the fault, so it can take up to N cycles to appear. The bench therefore uses small ratios for most modes and one full-size ratio for the largest count. A wrong state in the controller shows within one or two cycles of a preset change, as a pulse that is missing, extra, or off by one relative to the arming delay. The late-preset case is checked at exactly two and three counts remaining, to pin down the boundary.

// File: rtl/divn_pkg.sv
package divn_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_PRESET = 2'd0,
        ST_ARM    = 2'd1,
        ST_COUNT  = 2'd2
    } dv_state_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] first_max;
        logic [DIGIT_W-1:0] first_jam;
        logic [DIGIT_W-1:0] last_max;
        logic [DIGIT_W-1:0] last_jam;
    } dv_split_t;
endpackage

// File: rtl/divn_mode_split.sv
module divn_mode_split
    import divn_pkg::*;
(
    input  logic               sel_a,
    input  logic               sel_b,
    input  logic               sel_c,
    input  logic [DIGIT_W-1:0] low_jam,
    output dv_split_t          split
);
    always_comb begin
        split = '0;
        case ({sel_a, sel_b, sel_c})
            3'b111: begin
                split.first_max = 4'd1;
                split.first_jam = {3'b000, low_jam[0]};
                split.last_max  = 4'd7;
                split.last_jam  = {1'b0, low_jam[3:1]};
            end
            3'b011: begin
                split.first_max = 4'd3;
                split.first_jam = {2'b00, low_jam[1:0]};
                split.last_max  = 4'd3;
                split.last_jam  = {2'b00, low_jam[3:2]};
            end
            3'b101: begin
                split.first_max = 4'd4;
                split.first_jam = (low_jam[2:0] > 3'd4) ? 4'd4 : {1'b0, low_jam[2:0]};
                split.last_max  = 4'd1;
                split.last_jam  = {3'b000, low_jam[3]};
            end
            3'b001: begin
                split.first_max = 4'd7;
                split.first_jam = {1'b0, low_jam[2:0]};
                split.last_max  = 4'd1;
                split.last_jam  = {3'b000, low_jam[3]};
            end
            default: begin
                split.first_max = 4'd9;
                split.first_jam = (low_jam > 4'd9) ? 4'd9 : low_jam;
                split.last_max  = 4'd0;
                split.last_jam  = 4'd0;
            end
        endcase
    end
endmodule

// File: rtl/divn_digit.sv
module divn_digit #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] val,
    output logic         zero
);
    assign zero = (val == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (dec) begin
            val <= zero ? wrap_val : val - 1'b1;
        end
    end
endmodule

// File: rtl/divn_counter.sv
module divn_counter
    import divn_pkg::*;
#(
    parameter int DECADES = 3,
    localparam int JAM_W  = DIGIT_W * (DECADES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             sel_c,
    input  logic             latch_en,
    input  logic [JAM_W-1:0] jam,
    output logic             q
);
    localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);

    dv_state_e state, state_nx;
    logic preset_req, load, step, pulse;
    dv_split_t split;
    logic [DIGIT_W-1:0] held_first_max, held_last_max;
    logic [DIGIT_W-1:0] first_val, last_val;
    logic first_zero, last_zero;
    logic [DECADES-1:0][DIGIT_W-1:0] dec_val;
    logic [DECADES-1:0] dec_zero;
    logic [DECADES:0] borrow;
    logic upper_zero, above_one_zero, terminal, near_end;

    assign preset_req = !sel_b && !sel_c;

    divn_mode_split u_split (
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .sel_c  (sel_c),
        .low_jam(jam[DIGIT_W-1:0]),
        .split  (split)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_first_max <= '0;
            held_last_max  <= '0;
        end else if (load) begin
            held_first_max <= split.first_max;
            held_last_max  <= split.last_max;
        end
    end

    divn_digit #(.W(DIGIT_W)) u_first (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(split.first_jam),
        .dec(step), .wrap_val(held_first_max), .val(first_val), .zero(first_zero)
    );
    assign borrow[0] = step && first_zero;

    for (genvar i = 0; i < DECADES; i++) begin : g_decade
        logic [DIGIT_W-1:0] raw;
        assign raw = jam[DIGIT_W*(i+1) +: DIGIT_W];
        divn_digit #(.W(DIGIT_W)) u_dec (
            .clk(clk), .rst_n(rst_n), .load(load),
            .load_val((raw > NINE) ? NINE : raw),
            .dec(borrow[i]), .wrap_val(NINE), .val(dec_val[i]), .zero(dec_zero[i])
        );
        assign borrow[i+1] = borrow[i] && dec_zero[i];
    end

    divn_digit #(.W(DIGIT_W)) u_last (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(split.last_jam),
        .dec(borrow[DECADES]), .wrap_val(held_last_max), .val(last_val), .zero(last_zero)
    );

    always_comb begin
        above_one_zero = last_zero;
        for (int i = 1; i < DECADES; i++) begin
            above_one_zero = above_one_zero && dec_zero[i];
        end
        upper_zero = above_one_zero && dec_zero[0];
        terminal   = upper_zero && (first_val <= DIGIT_W'(1));
        near_end   = (upper_zero && (first_val <= DIGIT_W'(2)))
                  || (above_one_zero && (dec_val[0] == DIGIT_W'(1))
                      && (held_first_max == DIGIT_W'(1)) && first_zero);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRESET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        step     = 1'b0;
        pulse    = 1'b0;
        unique case (state)
            ST_PRESET: begin
                if (!preset_req) begin
                    state_nx = ST_ARM;
                    load     = 1'b1;
                end
            end
            ST_ARM: begin
                state_nx = preset_req ? ST_PRESET : ST_COUNT;
            end
            ST_COUNT: begin
                if (terminal) begin
                    pulse = 1'b1;
                    if (preset_req) state_nx = ST_PRESET;
                    else            load = 1'b1;
                end else if (preset_req && !near_end) begin
                    state_nx = ST_PRESET;
                end else begin
                    step = 1'b1;
                end
            end
            default: state_nx = ST_PRESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= pulse || (latch_en && q);
    end
endmodule

// File: rtl/divn_checker.sv
module divn_checker
    import divn_pkg::*;
#(
    parameter int DECADES = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input dv_state_e                         state,
    input logic                              preset_req,
    input logic                              pulse,
    input logic                              latch_en,
    input logic                              q,
    input logic [DECADES-1:0][DIGIT_W-1:0]   dec_val
);
    p_preset_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRESET && !preset_req) |=> (state == ST_ARM));

    p_arm_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |-> ($past(state) == ST_PRESET));

    p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !latch_en && !pulse) |=> !q);

    p_rise_in_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> ($past(state) == ST_COUNT));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && q) |=> q);

    p_parked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRESET && !latch_en) |=> !q);

    for (genvar i = 0; i < DECADES; i++) begin : g_rng
        p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            dec_val[i] <= DIGIT_W'(9));
    end
endmodule

bind divn_counter divn_checker #(.DECADES(DECADES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .preset_req(preset_req),
    .pulse     (pulse),
    .latch_en  (latch_en),
    .q         (q),
    .dec_val   (dec_val)
);

// File: tb/divn_counter_test.sv
module divn_counter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a = 1'b1, sel_b = 1'b0, sel_c = 1'b0;
    logic latch_en = 1'b0;
    logic [15:0] jam = '0;
    logic q;

    int checks = 0, fails = 0, cycles = 0;
    int m_st = 0, m_rem = 0;
    bit m_q = 1'b0;
    string tag = "R9";

    divn_counter uut (
        .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .latch_en(latch_en), .jam(jam), .q(q)
    );

    always #5 clk = ~clk;

    function automatic int min_i(int x, int y);
        return (x < y) ? x : y;
    endfunction

    function automatic int calc_n(logic a, logic b, logic c, logic [15:0] j);
        int m, f, l, d1, d2, d3;
        case ({a, b, c})
            3'b111: begin m = 2; f = j[0];   l = j[3:1]; end
            3'b011: begin m = 4; f = j[1:0]; l = j[3:2]; end
            3'b101: begin m = 5; f = min_i(j[2:0], 4); l = j[3]; end
            3'b001: begin m = 8; f = j[2:0]; l = j[3]; end
            default: begin m = 10; f = min_i(j[3:0], 9); l = 0; end
        endcase
        d1 = min_i(j[7:4], 9);
        d2 = min_i(j[11:8], 9);
        d3 = min_i(j[15:12], 9);
        return m * (1000 * l + 100 * d3 + 10 * d2 + d1) + f;
    endfunction

    task automatic model_edge();
        bit pm, pl;
        pm = !sel_b && !sel_c;
        pl = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_q = 1'b0;
            return;
        end
        case (m_st)
            0: if (!pm) begin m_st = 1; m_rem = calc_n(sel_a, sel_b, sel_c, jam); end
            1: m_st = pm ? 0 : 2;
            default: begin
                if (m_rem <= 1) begin
                    pl = 1'b1;
                    if (pm) m_st = 0;
                    else    m_rem = calc_n(sel_a, sel_b, sel_c, jam);
                end else if (pm && m_rem > 2) begin
                    m_st = 0;
                end else begin
                    m_rem = m_rem - 1;
                end
            end
        endcase
        m_q = pl || (latch_en && m_q);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        checks++;
        if (q !== m_q) begin
            fails++;
            $display("FAIL %s cycle %0d: q=%0b expected %0b", tag, cycles, q, m_q);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic park(int n);
        sel_b = 1'b0; sel_c = 1'b0;
        ticks(n);
    endtask

    task automatic run_mode(logic a, logic b, logic c, logic [15:0] j, int n);
        park(3);
        sel_a = a; sel_b = b; sel_c = c; jam = j;
        ticks(n);
    endtask

    initial begin
        // R9: reset holds q low
        tag = "R9";
        ticks(3);
        rst_n = 1'b1;
        // R4: parked with sel_a toggling, no pulse
        tag = "R4";
        ticks(2); sel_a = 1'b0; ticks(3);
        // R5 and R1: /2 mode, N = 25, first pulse after the arming cycle
        tag = "R5";
        run_mode(1'b1, 1'b1, 1'b1, 16'h0121, 30);
        tag = "R1";
        ticks(60);
        // R3: /4 mode, N = 15, change jam mid-count, new value used at reload
        tag = "R3";
        run_mode(1'b0, 1'b1, 1'b1, 16'h0033, 40);
        jam = 16'h0052;
        ticks(70);
        // R2: /5 mode with first jam clamped (7 -> 4), N = 14
        tag = "R2";
        run_mode(1'b1, 1'b0, 1'b1, 16'h0027, 60);
        // R1: /8 mode, N = 94
        tag = "R1";
        run_mode(1'b0, 1'b0, 1'b1, 16'h0116, 200);
        // R2: /10 mode with clamped low nibble and digit, N = 99
        tag = "R2";
        run_mode(1'b1, 1'b1, 1'b0, 16'h00CF, 210);
        // R1: sel_a ignored in the /10 code
        tag = "R1";
        run_mode(1'b0, 1'b1, 1'b0, 16'h0025, 120);
        // R7: latch holds q, then release
        tag = "R7";
        latch_en = 1'b1;
        ticks(80);
        latch_en = 1'b0;
        ticks(30);
        // R6: preset with two counts left still yields the pulse
        tag = "R6";
        run_mode(1'b0, 1'b0, 1'b1, 16'h0116, 20);
        while (m_rem != 2) tick();
        park(5);
        // R6: preset with three counts left parks at once
        sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b1;
        ticks(20);
        while (m_rem != 3) tick();
        park(5);
        // R8: N of 0 and 1
        tag = "R8";
        run_mode(1'b1, 1'b1, 1'b0, 16'h0000, 10);
        run_mode(1'b1, 1'b1, 1'b1, 16'h0001, 10);
        // R4: preset mid-count stops output
        tag = "R4";
        run_mode(1'b1, 1'b1, 1'b0, 16'h0050, 25);
        park(60);
        // R2: largest /2 ratio 15999 and large last section 14000
        tag = "R2";
        run_mode(1'b1, 1'b1, 1'b1, 16'hFFFF, 16100);
        run_mode(1'b1, 1'b1, 1'b1, 16'h000E, 14100);
        // R9: asynchronous reset during counting
        tag = "R9";
        @(negedge clk);
        rst_n = 1'b0;
        m_st = 0; m_q = 1'b0;
        ticks(2);
        checks++;
        if (q !== 1'b0) begin
            fails++;
            $display("FAIL R9: q=%0b expected 0", q);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(190000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog: q=%0b expected run end", q);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule